// File: doc/BRIEF.md
# Word-Clock Ratio Detector and Lock Monitor

This block sits in the system-clock domain of a slave-mode audio serial port. It measures the length of every word-clock period in system-clock cycles and works out which of four legal ratios the system clock runs at: 256, 384, 512 or 768 times the sample rate. It then watches each later period to confirm that the word clock stays locked to the system clock. The word clock reaches the block already synchronised into the system-clock domain.

The drift tolerance is counted in bit-clock units. One bit clock lasts the ratio divided by the frame length in system clocks. A frame-length input chooses between 64-bit and 48-bit frames. If one period moves outside the tolerance, or the word clock stops, the lock flag drops and a mute request asks the output stage to send the bipolar-zero code. The block then hunts for a legal ratio again. It holds the mute for a further settling run of periods before it reports lock.

Top module: `ratio_sync_monitor`

## Requirements
- R1: While reset is low, and in the cycle after it, `locked` is 0, `muteReq` is 1 and `ratioCode` is 0.
- R2: `ratioCode` gives the acquired ratio as 0 = 256, 1 = 384, 2 = 512 and 3 = 768 system clocks per word-clock period. It does not change while `locked` stays high.
- R3: While locked, a period shorter than the reference by more than the tolerance drops `locked` in the cycle its closing rising edge is registered. A period longer than the reference drops `locked` in the cycle its count first exceeds reference plus tolerance. If that is also the cycle of the closing edge, the result is the same.
- R4: While locked, a period that differs from the reference by no more than the tolerance, in either direction, keeps `locked` high.
- R5: The tolerance in system clocks is floor(5·ratio/64) when `frameShort` = 0 (64-bit frames) and floor(4·ratio/48) when `frameShort` = 1 (48-bit frames). For 768 this is 60 and 64 clocks.
- R6: After the first rising edge, a period that lies within tolerance of a legal ratio starts settling on that ratio. `locked` rises only on the closing edge of the 33rd consecutive matching period, which leaves 32 further sample periods of mute. Any period that does not match sends the block back to hunting.
- R7: `muteReq` is the inverse of `locked` in every cycle.
- R8: Periods that lie within tolerance of no legal ratio keep `locked` at 0 and `muteReq` at 1.
- R9: If the word clock stops while locked, `locked` falls no later than reference plus tolerance plus one cycle after the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wordClk | input | 1 | Word clock, already synchronised to `clk` |
| frameShort | input | 1 | 0: 64-bit frames, 1: 48-bit frames |
| ratioCode | output | 2 | Acquired ratio code (see R2) |
| locked | output | 1 | Word clock locked to system clock |
| muteReq | output | 1 | Request to force the output to zero data |

## Verification
Two checks can fall in the same cycle: the over-length timeout of the period counter and the measurement taken on a word-clock rising edge. A locked stream receives a period exactly one clock longer than reference plus tolerance, so the closing edge arrives in the cycle the count first passes the window. The bench expects a single, clean loss of lock there. It also feeds a period exactly at the bound, where the timeout does not fire and the edge must keep lock. Both cases are judged at the ports in the cycle after the closing edge.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int NUM_RATIOS = 4;
  localparam int IDX_W      = $clog2(NUM_RATIOS);
  localparam int BASE_UNIT  = 128;

  // legal system-clock to word-clock ratios, ascending; index is the ratio code
  function automatic int ratioOf(input int idx);
    case (idx)
      0:       return 2 * BASE_UNIT;
      1:       return 3 * BASE_UNIT;
      2:       return 4 * BASE_UNIT;
      default: return 6 * BASE_UNIT;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_HUNT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_LOCK   = 2'd3
  } lock_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchRatio;
    logic clearSettle;
    logic incSettle;
  } dp_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic anyHit;
    logic matchRef;
    logic overRef;
    logic settleDone;
  } dp_stat_t;

endpackage

// File: rtl/ratio_meas_dp.sv
module ratio_meas_dp
  import clkratio_pkg::*;
#(
  parameter int FRAME_LONG     = 64,
  parameter int FRAME_SHORT    = 48,
  parameter int TOL_LONG       = 5,
  parameter int TOL_SHORT      = 4,
  parameter int SETTLE_PERIODS = 32,
  parameter int CNT_W          = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wordClk,
  input  logic             frameShort,
  input  dp_ctrl_t         ctrl,
  output dp_stat_t         stat,
  output logic [IDX_W-1:0] ratioCode
);

  localparam int SET_W = $clog2(SETTLE_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_PERIODS - 1);

  logic                  wPrev;
  logic                  edgeSeen;
  logic [CNT_W-1:0]      periodCnt;
  logic [IDX_W-1:0]      ratioReg;
  logic [IDX_W-1:0]      hitIdx;
  logic [SET_W-1:0]      settleCnt;
  logic [NUM_RATIOS-1:0] hit;
  logic [CNT_W-1:0]      hiBound [NUM_RATIOS];

  assign edgeSeen = wordClk & ~wPrev;

  // one acceptance window per legal ratio, bounds fixed at elaboration
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
    localparam int RV    = ratioOf(g);
    localparam int TOL_L = (RV * TOL_LONG) / FRAME_LONG;
    localparam int TOL_S = (RV * TOL_SHORT) / FRAME_SHORT;
    localparam logic [CNT_W-1:0] LO_L = CNT_W'(RV - TOL_L);
    localparam logic [CNT_W-1:0] HI_L = CNT_W'(RV + TOL_L);
    localparam logic [CNT_W-1:0] LO_S = CNT_W'(RV - TOL_S);
    localparam logic [CNT_W-1:0] HI_S = CNT_W'(RV + TOL_S);

    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;

    assign lo         = frameShort ? LO_S : LO_L;
    assign hi         = frameShort ? HI_S : HI_L;
    assign hit[g]     = (periodCnt >= lo) && (periodCnt <= hi);
    assign hiBound[g] = hi;
  end

  // windows do not overlap; lowest index wins if they ever did
  always_comb begin
    hitIdx = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) hitIdx = IDX_W'(i);
    end
  end

  always_comb begin
    stat.edgeSeen   = edgeSeen;
    stat.anyHit     = |hit;
    stat.matchRef   = hit[ratioReg];
    stat.overRef    = periodCnt > hiBound[ratioReg];
    stat.settleDone = settleCnt == SET_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wPrev     <= 1'b0;
      periodCnt <= '0;
      ratioReg  <= '0;
      settleCnt <= '0;
    end else begin
      wPrev <= wordClk;
      if (edgeSeen)                 periodCnt <= CNT_W'(1);
      else if (periodCnt != CNT_MAX) periodCnt <= periodCnt + CNT_W'(1);
      if (ctrl.latchRatio) ratioReg <= hitIdx;
      if (ctrl.clearSettle)    settleCnt <= '0;
      else if (ctrl.incSettle) settleCnt <= settleCnt + SET_W'(1);
    end
  end

  assign ratioCode = ratioReg;

endmodule

// File: rtl/ratio_lock_ctrl.sv
module ratio_lock_ctrl
  import clkratio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dp_stat_t stat,
  output dp_ctrl_t ctrl,
  output logic     lockedQ
);

  lock_state_e state;
  lock_state_e stateNext;
  logic        lost;

  // a period outside the reference window, caught by timeout or at its edge
  assign lost = stat.overRef || (stat.edgeSeen && !stat.matchRef);

  always_comb begin
    stateNext        = state;
    ctrl.latchRatio  = 1'b0;
    ctrl.clearSettle = 1'b0;
    ctrl.incSettle   = 1'b0;
    case (state)
      ST_WAIT: begin
        if (stat.edgeSeen) stateNext = ST_HUNT;
      end
      ST_HUNT: begin
        if (stat.edgeSeen && stat.anyHit) begin
          stateNext        = ST_SETTLE;
          ctrl.latchRatio  = 1'b1;
          ctrl.clearSettle = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (lost) begin
          stateNext = ST_HUNT;
        end else if (stat.edgeSeen) begin
          if (stat.settleDone) stateNext = ST_LOCK;
          else                 ctrl.incSettle = 1'b1;
        end
      end
      default: begin
        if (lost) stateNext = ST_HUNT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= stateNext;
  end

  assign lockedQ = (state == ST_LOCK);

endmodule

// File: rtl/ratio_sync_monitor.sv
module ratio_sync_monitor
  import clkratio_pkg::*;
#(
  parameter int FRAME_LONG     = 64,
  parameter int FRAME_SHORT    = 48,
  parameter int TOL_LONG       = 5,
  parameter int TOL_SHORT      = 4,
  parameter int SETTLE_PERIODS = 32,
  parameter int CNT_W          = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wordClk,
  input  logic             frameShort,
  output logic [IDX_W-1:0] ratioCode,
  output logic             locked,
  output logic             muteReq
);

  dp_ctrl_t dpCtrl;
  dp_stat_t dpStat;

  ratio_meas_dp #(
    .FRAME_LONG    (FRAME_LONG),
    .FRAME_SHORT   (FRAME_SHORT),
    .TOL_LONG      (TOL_LONG),
    .TOL_SHORT     (TOL_SHORT),
    .SETTLE_PERIODS(SETTLE_PERIODS),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wordClk   (wordClk),
    .frameShort(frameShort),
    .ctrl      (dpCtrl),
    .stat      (dpStat),
    .ratioCode (ratioCode)
  );

  ratio_lock_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (dpStat),
    .ctrl   (dpCtrl),
    .lockedQ(locked)
  );

  assign muteReq = ~locked;

endmodule

// File: rtl/ratio_sync_chk.sv
module ratio_sync_chk
  import clkratio_pkg::*;
#(
  parameter int FRAME_LONG  = 64,
  parameter int FRAME_SHORT = 48,
  parameter int TOL_LONG    = 5,
  parameter int TOL_SHORT   = 4,
  parameter int CNT_W       = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wordClk,
  input logic [IDX_W-1:0] ratioCode,
  input logic             locked
);

  localparam int TOP_RATIO = ratioOf(NUM_RATIOS - 1);
  localparam int TOL_L     = (TOP_RATIO * TOL_LONG) / FRAME_LONG;
  localparam int TOL_S     = (TOP_RATIO * TOL_SHORT) / FRAME_SHORT;
  localparam int MAX_WAIT  = TOP_RATIO + ((TOL_L > TOL_S) ? TOL_L : TOL_S) + 1;
  localparam logic [CNT_W-1:0] IDLE_MAX = '1;

  logic             prevW;
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevW   <= 1'b0;
      idleCnt <= '0;
    end else begin
      prevW <= wordClk;
      if (wordClk && !prevW)       idleCnt <= CNT_W'(1);
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  // R2: the reported ratio holds while lock holds
  a_r2_ratio_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ratioCode));

  // R6: lock is only granted on a word-clock rising edge
  a_r6_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(wordClk) && !$past(wordClk, 2)));

  // R6: losing lock always passes through a settling run
  a_r6_no_quick_relock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |=> !locked);

  // R9: lock never survives a silent word clock beyond the widest window
  a_r9_halt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (idleCnt <= CNT_W'(MAX_WAIT)));

endmodule

bind ratio_sync_monitor ratio_sync_chk #(
  .FRAME_LONG (FRAME_LONG),
  .FRAME_SHORT(FRAME_SHORT),
  .TOL_LONG   (TOL_LONG),
  .TOL_SHORT  (TOL_SHORT),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wordClk  (wordClk),
  .ratioCode(ratioCode),
  .locked   (locked)
);

// File: tb/tb_ratio_sync_monitor.sv
`timescale 1ns/1ps
module tb_ratio_sync_monitor;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wordClk;
  logic       frameShort;
  logic [1:0] ratioCode;
  logic       locked;
  logic       muteReq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ratio_sync_monitor dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wordClk   (wordClk),
    .frameShort(frameShort),
    .ratioCode (ratioCode),
    .locked    (locked),
    .muteReq   (muteReq)
  );

  typedef struct packed {
    int         period;
    int         reps;
    logic       short48;
    logic       expLock;
    logic [1:0] expRatio;
    int         req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{384, 32, 1'b0, 1'b0, 2'd1, 6},  // R6 one period short of lock
    '{384,  1, 1'b0, 1'b1, 2'd1, 6},  // R6 R2 lock on 33rd period, code 1
    '{408,  1, 1'b0, 1'b1, 2'd1, 4},  // R4 +4 bit clocks
    '{414,  1, 1'b0, 1'b1, 2'd1, 4},  // R4 +5 bit clocks, window edge
    '{354,  1, 1'b0, 1'b1, 2'd1, 4},  // R4 -5 bit clocks
    '{353,  1, 1'b0, 1'b0, 2'd1, 3},  // R3 short period trips
    '{384, 33, 1'b0, 1'b1, 2'd1, 6},  // R6 reacquire
    '{415,  1, 1'b0, 1'b0, 2'd1, 3},  // R3 timeout and edge same cycle
    '{256, 33, 1'b0, 1'b1, 2'd0, 2},  // R2 code 0
    '{276,  1, 1'b0, 1'b1, 2'd0, 4},  // R4 256 window edge
    '{512, 33, 1'b0, 1'b1, 2'd2, 2},  // R2 R3 ratio change, code 2
    '{768, 33, 1'b0, 1'b1, 2'd3, 2},  // R2 code 3
    '{828,  1, 1'b0, 1'b1, 2'd3, 5},  // R5 64-bit frame tolerance 60
    '{832,  1, 1'b0, 1'b0, 2'd3, 5},  // R5 beyond 60
    '{768, 33, 1'b1, 1'b1, 2'd3, 6},  // R6 acquire with 48-bit frames
    '{832,  1, 1'b1, 1'b1, 2'd3, 5},  // R5 48-bit frame tolerance 64
    '{833,  1, 1'b1, 1'b0, 2'd3, 5},  // R5 beyond 64
    '{300, 40, 1'b0, 1'b0, 2'd0, 8}   // R8 illegal ratio never locks
  };

  // each period closes with a rising edge driven at a falling clock edge
  task automatic runPeriods(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      repeat (p / 2) @(negedge clk);
      wordClk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
      wordClk = 1'b1;
    end
  endtask

  // R7: mute is compared against the inverse of the expected lock every time
  task automatic checkOut(input string tag, input logic expL,
                          input logic [1:0] expR, input logic chkR);
    nChecks++;
    if (locked !== expL || muteReq !== ~expL || (chkR && ratioCode !== expR)) begin
      nFail++;
      $display("FAIL %s: locked=%0b muteReq=%0b ratioCode=%0d, expected locked=%0b muteReq=%0b ratioCode=%0d",
               tag, locked, muteReq, ratioCode, expL, ~expL, expR);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    rst_n      = 1'b0;
    wordClk    = 1'b0;
    frameShort = 1'b0;
    repeat (5) @(negedge clk);
    checkOut("R1 reset state", 1'b0, 2'd0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    wordClk = 1'b1;   // first rising edge only arms the hunt

    for (int v = 0; v < NV; v++) begin
      frameShort = VECS[v].short48;
      runPeriods(VECS[v].period, VECS[v].reps);
      @(posedge clk); #1;
      checkOut($sformatf("R%0d vector %0d", VECS[v].req, v),
               VECS[v].expLock, VECS[v].expRatio, VECS[v].expLock);
    end

    // R6 reacquire after illegal stream
    frameShort = 1'b0;
    runPeriods(384, 33);
    @(posedge clk); #1;
    checkOut("R6 relock at 384", 1'b1, 2'd1, 1'b1);

    // R9 stopped word clock: still inside window, then past it
    repeat (400) @(negedge clk);
    @(posedge clk); #1;
    checkOut("R9 idle within window", 1'b1, 2'd1, 1'b1);
    repeat (20) @(negedge clk);
    @(posedge clk); #1;
    checkOut("R9 idle past window", 1'b0, 2'd1, 1'b0);

    // R1 reset clears the acquired ratio
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    checkOut("R1 reset clears ratio", 1'b0, 2'd0, 1'b1);

    finishRun();
  end

endmodule